// File: doc/BRIEF.md
# Page-mapped flash translation controller

This block is a small hardware translation layer between a host port and a flash page array. The host issues single-page reads, writes and trims against logical page numbers. The controller never programs a page twice between erases. Every write lands on the next erased page of the currently open block, and the logical-to-physical map is updated to point at that page. The superseded copy of the data is only marked stale. A per-page valid bit, a reverse map from physical to logical pages, a per-block erase counter and a free-block set are all held in registers.

When a block fills, the controller opens a new block. It chooses the free block with the lowest erase count, so that wear spreads across the array. After a host write, if the free pool has shrunk to the collection limit, the controller reclaims one used block. It relocates that block's live pages into the open block, repoints the map at the new copies, erases the block and counts the erase. Two counters, one for host pages and one for physical pages programmed (copies included), let the write amplification be read directly as their ratio.

Top module: `ftl_ctrl`

## Requirements
- R1: After reset, all NBLK blocks are free (`free_blocks` = NBLK), both page counters are zero, `busy` is low, and every logical page is unmapped.
- R2: Every program goes to a page that has not been programmed since its block was last erased. The physical page number is block*PPB + page index, with PPB a power of two. Pages within an open block are used in ascending order starting at index 0. A rewrite of a logical page therefore gets a new physical page. A write response reports the physical page it used.
- R3: The op codes are 2'b00 read, 2'b01 write and 2'b10 trim; 2'b11 is answered and changes nothing. A read of a mapped page returns the data of the last write to that logical page and its physical page number, with `resp_unmapped` low.
- R4: A trim unmaps the logical page and programs nothing. A later read of an unmapped page returns all-ones data with `resp_unmapped` high.
- R5: A new block is opened only when there is no open block or the open block is full. The block chosen is the free block with the smallest erase count, and a tie goes to the lowest block number.
- R6: Collection starts after a host write completes if `free_blocks` <= GC_LIMIT (default 1). The block reclaimed is the one, among blocks that are neither free nor open, with the fewest valid pages; a tie goes to the lowest block number.
- R7: Collection copies the victim's valid pages in ascending page order into the open block and repoints the map. It then erases the victim, adds one to its erase count and returns it to the free pool.
- R8: `host_pages` adds one per host write, and `phys_pages` adds one per programmed page, including collection copies.
- R9: A request is accepted only while `busy` is low. `busy` stays high from the acceptance of a read or write until that operation and any collection it triggers are finished. A request presented while `busy` is high has no effect.
- R10: `resp_valid` is a single-cycle pulse per accepted request. For a write, the pulse comes in the cycle after the page is programmed, before any collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | Operation code |
| req_lpn | input | LW | Logical page number |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Controller not idle |
| resp_valid | output | 1 | Response pulse |
| resp_data | output | DW | Read data, or written data on a write |
| resp_ppn | output | PAW | Physical page read or programmed |
| resp_unmapped | output | 1 | Read target was unmapped |
| free_blocks | output | FCW | Number of free blocks |
| host_pages | output | CW | Host pages written |
| phys_pages | output | CW | Physical pages programmed |

## Verification
A corrupted map entry or reverse-map entry shows up at the next read of that logical page as wrong data or a wrong physical page number. It can also show up one collection later, when a live page is left behind or a stale one is copied and `phys_pages` drifts from its predicted total. A wrong erase counter or free set cannot be seen at once. It surfaces only at the next block opening, as an unexpected physical page number in a write response. The bench therefore drives the array through three collections and checks the placement of every write, so that each allocation decision is exposed within one block of writes.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_TRIM  = 2'b10,
    OP_NONE  = 2'b11
  } ftl_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RDOUT,
    S_PLACE,
    S_GC_PICK,
    S_GC_SCAN,
    S_GC_LOAD,
    S_GC_ERASE
  } ftl_state_e;
endpackage

// File: rtl/ftl_page_store.sv
module ftl_page_store #(
  parameter int NBLK = 8,
  parameter int PPB  = 4,
  parameter int DW   = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [$clog2(NBLK*PPB)-1:0]         wr_addr,
  input  logic [DW-1:0]                       wr_data,
  input  logic [$clog2(NBLK*PPB)-1:0]         rd_addr,
  output logic [DW-1:0]                       rd_data,
  input  logic                                erase_en,
  input  logic [$clog2(NBLK)-1:0]             erase_blk
);
  localparam int NPAGE = NBLK * PPB;

  // data array without reset so that it maps onto block RAM
  logic [DW-1:0]    mem [NPAGE];
  // programmed-since-erase flag per page
  logic [NPAGE-1:0] used;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else begin
      if (erase_en) begin
        for (int p = 0; p < PPB; p++) used[int'(erase_blk) * PPB + p] <= 1'b0;
      end
      if (wr_en) used[wr_addr] <= 1'b1;
    end
  end

  AST_PROG_ERASED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !used[wr_addr]); // R2
endmodule

// File: rtl/ftl_wear_pick.sv
module ftl_wear_pick #(
  parameter int NBLK = 8,
  parameter int ECW  = 16
) (
  input  logic [NBLK-1:0]          blk_free,
  input  logic [ECW-1:0]           ecnt [NBLK],
  output logic                     pick_ok,
  output logic [$clog2(NBLK)-1:0]  pick_blk
);
  localparam int BW = $clog2(NBLK);

  logic [ECW-1:0] best;

  // strict less-than keeps the lowest index on equal counts
  always_comb begin
    pick_ok  = 1'b0;
    pick_blk = '0;
    best     = '1;
    for (int b = 0; b < NBLK; b++) begin
      if (blk_free[b] && (!pick_ok || ecnt[b] < best)) begin
        pick_ok  = 1'b1;
        pick_blk = BW'(b);
        best     = ecnt[b];
      end
    end
  end
endmodule

// File: rtl/ftl_gc_victim.sv
module ftl_gc_victim #(
  parameter int NBLK = 8,
  parameter int PPB  = 4
) (
  input  logic [NBLK-1:0]          blk_free,
  input  logic [NBLK*PPB-1:0]      pvalid,
  input  logic                     open_valid,
  input  logic [$clog2(NBLK)-1:0]  open_blk,
  output logic                     vic_ok,
  output logic [$clog2(NBLK)-1:0]  vic_blk
);
  localparam int BW  = $clog2(NBLK);
  localparam int CNW = $clog2(PPB + 1);

  logic [CNW-1:0] best;
  logic [CNW-1:0] live;
  logic           cand;

  always_comb begin
    vic_ok  = 1'b0;
    vic_blk = '0;
    best    = '1;
    live    = '0;
    cand    = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      live = CNW'($countones(pvalid[b*PPB +: PPB]));
      cand = !blk_free[b] && !(open_valid && (open_blk == BW'(b)));
      if (cand && (!vic_ok || live < best)) begin
        vic_ok  = 1'b1;
        vic_blk = BW'(b);
        best    = live;
      end
    end
  end
endmodule

// File: rtl/ftl_ctrl.sv
module ftl_ctrl #(
  parameter int NBLK     = 8,
  parameter int PPB      = 4,
  parameter int NLP      = 16,
  parameter int DW       = 16,
  parameter int ECW      = 16,
  parameter int CW       = 32,
  parameter int GC_LIMIT = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [1:0]                        req_op,
  input  logic [$clog2(NLP)-1:0]            req_lpn,
  input  logic [DW-1:0]                     req_wdata,
  output logic                              busy,
  output logic                              resp_valid,
  output logic [DW-1:0]                     resp_data,
  output logic [$clog2(NBLK*PPB)-1:0]       resp_ppn,
  output logic                              resp_unmapped,
  output logic [$clog2(NBLK+1)-1:0]         free_blocks,
  output logic [CW-1:0]                     host_pages,
  output logic [CW-1:0]                     phys_pages
);
  import ftl_pkg::*;

  localparam int NPAGE = NBLK * PPB;
  localparam int BW    = $clog2(NBLK);
  localparam int PGW   = $clog2(PPB);
  localparam int PAW   = BW + PGW;
  localparam int LW    = $clog2(NLP);
  localparam int FCW   = $clog2(NBLK + 1);
  localparam logic [PGW:0]   PPB_L = (PGW+1)'(PPB);
  localparam logic [FCW-1:0] LIM_L = FCW'(GC_LIMIT);

  ftl_state_e       state;

  // translation state
  logic [NLP-1:0]   map_ok;
  logic [PAW-1:0]   map_ppn [NLP];
  logic [NPAGE-1:0] pvalid;
  logic [LW-1:0]    plpn [NPAGE];
  logic [NBLK-1:0]  blk_free;
  logic [ECW-1:0]   ecnt [NBLK];
  logic             open_valid;
  logic [BW-1:0]    open_blk;
  logic [PGW:0]     wr_ptr;

  // operation in flight
  logic [LW-1:0]    cur_lpn;
  logic [DW-1:0]    cur_data;
  logic             from_gc;
  logic [BW-1:0]    vic;
  logic [PGW:0]     scan_idx;

  logic [CW-1:0]    host_cnt;
  logic [CW-1:0]    phys_cnt;

  logic             pick_ok;
  logic [BW-1:0]    pick_blk;
  logic             vic_ok;
  logic [BW-1:0]    vic_blk;
  logic             need_open;
  logic             prog_fire;
  logic [PAW-1:0]   prog_ppn;
  logic [PAW-1:0]   gc_addr;
  logic [PAW-1:0]   rd_addr;
  logic [DW-1:0]    rd_data;

  assign need_open   = !open_valid || (wr_ptr == PPB_L);
  assign prog_fire   = (state == S_PLACE) && !need_open;
  assign prog_ppn    = {open_blk, wr_ptr[PGW-1:0]};
  assign gc_addr     = {vic, scan_idx[PGW-1:0]};
  assign rd_addr     = (state == S_GC_SCAN) ? gc_addr : map_ppn[req_lpn];
  assign free_blocks = FCW'($countones(blk_free));
  assign busy        = (state != S_IDLE);
  assign host_pages  = host_cnt;
  assign phys_pages  = phys_cnt;

  ftl_page_store #(.NBLK(NBLK), .PPB(PPB), .DW(DW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (prog_fire),
    .wr_addr   (prog_ppn),
    .wr_data   (cur_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .erase_en  (state == S_GC_ERASE),
    .erase_blk (vic)
  );

  ftl_wear_pick #(.NBLK(NBLK), .ECW(ECW)) u_pick (
    .blk_free (blk_free),
    .ecnt     (ecnt),
    .pick_ok  (pick_ok),
    .pick_blk (pick_blk)
  );

  ftl_gc_victim #(.NBLK(NBLK), .PPB(PPB)) u_victim (
    .blk_free   (blk_free),
    .pvalid     (pvalid),
    .open_valid (open_valid),
    .open_blk   (open_blk),
    .vic_ok     (vic_ok),
    .vic_blk    (vic_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      map_ok        <= '0;
      pvalid        <= '0;
      blk_free      <= '1;
      open_valid    <= 1'b0;
      open_blk      <= '0;
      wr_ptr        <= '0;
      cur_lpn       <= '0;
      cur_data      <= '0;
      from_gc       <= 1'b0;
      vic           <= '0;
      scan_idx      <= '0;
      host_cnt      <= '0;
      phys_cnt      <= '0;
      resp_valid    <= 1'b0;
      resp_data     <= '1;
      resp_ppn      <= '0;
      resp_unmapped <= 1'b0;
      for (int i = 0; i < NLP; i++)   map_ppn[i] <= '0;
      for (int i = 0; i < NPAGE; i++) plpn[i]    <= '0;
      for (int i = 0; i < NBLK; i++)  ecnt[i]    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cur_lpn  <= req_lpn;
            cur_data <= req_wdata;
            from_gc  <= 1'b0;
            if (req_op == OP_READ) begin
              state <= S_RDOUT;
            end else if (req_op == OP_WRITE) begin
              state <= S_PLACE;
            end else begin
              if (req_op == OP_TRIM && map_ok[req_lpn]) begin
                pvalid[map_ppn[req_lpn]] <= 1'b0;
                map_ok[req_lpn]          <= 1'b0;
              end
              resp_valid    <= 1'b1;
              resp_unmapped <= 1'b0;
            end
          end
        end
        S_RDOUT: begin
          resp_valid <= 1'b1;
          if (map_ok[cur_lpn]) begin
            resp_data     <= rd_data;
            resp_ppn      <= map_ppn[cur_lpn];
            resp_unmapped <= 1'b0;
          end else begin
            resp_data     <= '1;
            resp_ppn      <= '0;
            resp_unmapped <= 1'b1;
          end
          state <= S_IDLE;
        end
        S_PLACE: begin
          if (need_open) begin
            if (pick_ok) begin
              open_blk           <= pick_blk;
              open_valid         <= 1'b1;
              wr_ptr             <= '0;
              blk_free[pick_blk] <= 1'b0;
            end
          end else begin
            if (map_ok[cur_lpn]) pvalid[map_ppn[cur_lpn]] <= 1'b0;
            pvalid[prog_ppn]  <= 1'b1;
            plpn[prog_ppn]    <= cur_lpn;
            map_ok[cur_lpn]   <= 1'b1;
            map_ppn[cur_lpn]  <= prog_ppn;
            wr_ptr            <= wr_ptr + 1'b1;
            phys_cnt          <= phys_cnt + 1'b1;
            if (from_gc) begin
              scan_idx <= scan_idx + 1'b1;
              state    <= S_GC_SCAN;
            end else begin
              host_cnt      <= host_cnt + 1'b1;
              resp_valid    <= 1'b1;
              resp_data     <= cur_data;
              resp_ppn      <= prog_ppn;
              resp_unmapped <= 1'b0;
              state         <= (free_blocks <= LIM_L) ? S_GC_PICK : S_IDLE;
            end
          end
        end
        S_GC_PICK: begin
          if (vic_ok) begin
            vic      <= vic_blk;
            scan_idx <= '0;
            from_gc  <= 1'b1;
            state    <= S_GC_SCAN;
          end else begin
            state <= S_IDLE;
          end
        end
        S_GC_SCAN: begin
          if (scan_idx == PPB_L) begin
            state <= S_GC_ERASE;
          end else if (pvalid[gc_addr]) begin
            cur_lpn <= plpn[gc_addr];
            state   <= S_GC_LOAD;
          end else begin
            scan_idx <= scan_idx + 1'b1;
          end
        end
        S_GC_LOAD: begin
          cur_data <= rd_data;
          state    <= S_PLACE;
        end
        S_GC_ERASE: begin
          blk_free[vic] <= 1'b1;
          ecnt[vic]     <= ecnt[vic] + 1'b1;
          for (int p = 0; p < PPB; p++) pvalid[int'(vic) * PPB + p] <= 1'b0;
          from_gc <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PHYS_GE_HOST: assert property (@(posedge clk) disable iff (rst)
    phys_cnt >= host_cnt); // R8
  AST_HOST_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(host_cnt) |-> (host_cnt == $past(host_cnt) + 1'b1)); // R8
  AST_OPEN_HAS_FREE: assert property (@(posedge clk) disable iff (rst)
    (state == S_PLACE && need_open) |-> pick_ok); // R5
  AST_VICTIM_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (state == S_GC_PICK && vic_ok) |-> (!blk_free[vic_blk] && !(open_valid && vic_blk == open_blk))); // R6
  AST_ERASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == S_GC_ERASE) |=> (ecnt[$past(vic)] == ECW'($past(ecnt[vic]) + 1'b1))); // R7
  AST_TRIM_NO_PROGRAM: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && req_valid && req_op == OP_TRIM) |=> $stable(phys_cnt)); // R4
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && state != S_IDLE) |=> !resp_valid); // R10
endmodule

// File: tb/ftl_ctrl_bench.sv
module ftl_ctrl_bench;
  localparam int LW  = 4;
  localparam int DW  = 16;
  localparam int PAW = 5;
  localparam int FCW = 4;
  localparam int CW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [1:0]     req_op = 2'b00;
  logic [LW-1:0]  req_lpn = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic           busy;
  logic           resp_valid;
  logic [DW-1:0]  resp_data;
  logic [PAW-1:0] resp_ppn;
  logic           resp_unmapped;
  logic [FCW-1:0] free_blocks;
  logic [CW-1:0]  host_pages;
  logic [CW-1:0]  phys_pages;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0]  got_data;
  logic [PAW-1:0] got_ppn;
  logic           got_unm;

  always #10ns clk = ~clk;

  ftl_ctrl u_ftl_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_lpn(req_lpn), .req_wdata(req_wdata), .busy(busy),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_ppn(resp_ppn),
    .resp_unmapped(resp_unmapped), .free_blocks(free_blocks),
    .host_pages(host_pages), .phys_pages(phys_pages)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic run_op(input logic [1:0] op, input int lpn, input logic [DW-1:0] d);
    int guard = 0;
    wait_idle();
    req_valid = 1'b1; req_op = op; req_lpn = LW'(lpn); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && guard < 2000) begin @(negedge clk); guard++; end
    got_data = resp_data; got_ppn = resp_ppn; got_unm = resp_unmapped;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 free_blocks", 32'(free_blocks), 8);
    check("R1 host_pages", host_pages, 0);
    check("R1 phys_pages", phys_pages, 0);
    check("R1 busy", 32'(busy), 0);
    run_op(2'b00, 7, '0);
    check("R1 unmapped flag", 32'(got_unm), 1);
    check("R4 unmapped data", 32'(got_data), 32'hFFFF);
  endtask

  task automatic t_basic();
    do_reset();
    run_op(2'b01, 3, 16'hA1A1);
    check("R2 first ppn", 32'(got_ppn), 0);
    @(negedge clk);
    check("R10 pulse width", 32'(resp_valid), 0);
    run_op(2'b01, 3, 16'hB2B2);
    check("R2 rewrite ppn", 32'(got_ppn), 1);
    run_op(2'b00, 3, '0);
    check("R3 read data", 32'(got_data), 32'hB2B2);
    check("R3 read ppn", 32'(got_ppn), 1);
    check("R3 mapped flag", 32'(got_unm), 0);
    run_op(2'b11, 3, '0);
    run_op(2'b00, 3, '0);
    check("R3 nop keeps data", 32'(got_data), 32'hB2B2);
    run_op(2'b10, 3, '0);
    run_op(2'b00, 3, '0);
    check("R4 trimmed flag", 32'(got_unm), 1);
    check("R4 trimmed data", 32'(got_data), 32'hFFFF);
    check("R4 no program", phys_pages, 2);
    check("R8 host count", host_pages, 2);
    check("R5 one block open", 32'(free_blocks), 7);
  endtask

  task automatic t_fill_gc();
    int seq [25] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,1,2,3,4,5,8,9,10,13};
    do_reset();
    for (int k = 0; k < 25; k++) begin
      run_op(2'b01, seq[k], DW'(16'h1000 + k + 1));
      check("R2 fill placement", 32'(got_ppn), k);
    end
    check("R9 busy during collection", 32'(busy), 1);
    req_valid = 1'b1; req_op = 2'b01; req_lpn = 4'd9; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    check("R9 ignored request count", host_pages, 25);
    check("R8 phys with copy", phys_pages, 26);
    check("R7 block returned", 32'(free_blocks), 2);
    run_op(2'b00, 9, '0);
    check("R9 ignored data", 32'(got_data), 32'h1000 + 23);
    check("R9 ignored ppn", 32'(got_ppn), 22);
    run_op(2'b00, 0, '0);
    check("R7 copy data", 32'(got_data), 32'h1001);
    check("R7 copy ppn", 32'(got_ppn), 25);
    run_op(2'b00, 11, '0);
    check("R6 tie victim lowest", 32'(got_ppn), 11);
  endtask

  task automatic t_wear();
    run_op(2'b01, 14, 16'h2001);
    check("R2 open block fill", 32'(got_ppn), 26);
    run_op(2'b01, 15, 16'h2002);
    run_op(2'b01, 2, 16'h2003);
    check("R5 least worn block", 32'(got_ppn), 28);
    wait_idle();
    run_op(2'b00, 11, '0);
    check("R6 fewest valid victim", 32'(got_ppn), 29);
    check("R7 relocated data", 32'(got_data), 32'h1000 + 12);
    check("R8 host after second", host_pages, 28);
    check("R8 phys after second", phys_pages, 30);
    check("R7 free after second", 32'(free_blocks), 2);
  endtask

  task automatic t_wear_tie();
    run_op(2'b01, 3, 16'h3001);
    run_op(2'b01, 4, 16'h3002);
    run_op(2'b01, 5, 16'h3003);
    check("R5 equal wear lowest block", 32'(got_ppn), 0);
    wait_idle();
    run_op(2'b00, 12, '0);
    check("R7 copy after open page", 32'(got_ppn), 1);
    check("R7 copy data third", 32'(got_data), 32'h1000 + 13);
    run_op(2'b00, 1, '0);
    check("R6 tie keeps higher block", 32'(got_ppn), 16);
    check("R8 write amplification phys", phys_pages, 34);
    check("R8 write amplification host", host_pages, 31);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic();
    t_fill_gc();
    t_wear();
    t_wear_tie();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule